// File: doc/BRIEF.md
# Row Zero-Suppression Run Encoder

This block sits behind a pixel row whose one-bit discriminator results arrive in parallel, one row per row period. It drops every pixel that carries no hit and describes the hit pixels as groups of contiguous hits. Each output record holds three things: the column of the group's first pixel, a two-bit code for the group length, and the number of the row it came from. A group covers at most four adjacent pixels. A longer run is cut into several groups.

A row enters through a valid/ready handshake and is held in a pending mask. Each record taken downstream clears the pixels it covers from that mask. Records leave in ascending column order through a valid/ready stream, one per cycle while the consumer is ready. The final record of a row carries an end-of-row flag. A row without hits is taken and dropped, and it produces nothing. The next row is accepted only once every record of the current row has been taken. Row width and row-number width are parameters.

Top module: `zs_row_encoder`

## Requirements
- R1: After reset `rec_valid` is 0 and `row_ready` is 1.
- R2: Each group of contiguous hit pixels gives one record. `rec_col` is the column of the group's lowest pixel. `rec_len` holds the group length minus one: 00 means 1 pixel, 01 means 2, 10 means 3, 11 means 4.
- R3: A run of more than four contiguous hits is cut into groups of four, taken from the lowest column upward. Each group starts at the first pixel not yet covered, and a last group of 1 to 3 pixels takes what is left.
- R4: Within a row, records appear in strictly ascending `rec_col` order. Each record starts above the last pixel of the record before it.
- R5: A row with no hits (`row_hits` all zero) produces no record. `row_ready` stays 1 after it is taken.
- R6: Every record carries in `rec_row` the `row_index` sampled when its row was accepted. `rec_last` is 1 on the final record of a row and 0 on all the others.
- R7: `row_ready` goes to 0 in the cycle after a row with hits is accepted. It returns to 1 in the cycle after the handshake of that row's final record, and stays 0 in between.
- R8: While `rec_valid` is 1 and `rec_ready` is 0, the record fields hold their values and `rec_valid` stays 1.
- R9: A group that ends at column COLS-1, or starts at column 0, is coded like any other group. A group never reaches past column COLS-1.
- R10: With `rec_ready` held at 1, a row that yields N records gives them in N consecutive cycles, starting in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_valid | input | 1 | A row is offered |
| row_ready | output | 1 | The block can accept a row |
| row_hits | input | COLS | Discriminator bit per column; bit c is column c |
| row_index | input | ROW_W | Number of the offered row |
| rec_valid | output | 1 | A record is offered |
| rec_ready | input | 1 | Consumer takes the record |
| rec_col | output | $clog2(COLS) | Column of the group's first pixel |
| rec_len | output | 2 | Group length minus one |
| rec_row | output | ROW_W | Row number of the record |
| rec_last | output | 1 | Final record of the row |

## Verification
The hardest situation to reach is a consumer stall that falls on a group cut from a run longer than four pixels. When that happens, the split point, the pending mask and the row tag must all survive the wait. The same applies to a new row that is already offered while the final record of the previous row is leaving. To reach these cases, the stimulus mixes dense rows with sparse ones and toggles `rec_ready` at random. It also keeps `row_valid` asserted across row boundaries. A behavioural queue model compares every output on every cycle, so each of these cases is checked wherever it happens to occur.

// File: rtl/zs_pkg.sv
package zs_pkg;

    localparam int RUN_MAX = 4;
    localparam int LEN_W   = 2;

    typedef enum logic [LEN_W-1:0] {
        LEN_ONE   = 2'b00,
        LEN_TWO   = 2'b01,
        LEN_THREE = 2'b10,
        LEN_FOUR  = 2'b11
    } run_len_e;

    // tail holds the three pixels after the group start (bit 0 is nearest)
    function automatic run_len_e run_code(input logic [RUN_MAX-2:0] tail);
        run_len_e c;
        if (!tail[0])      c = LEN_ONE;
        else if (!tail[1]) c = LEN_TWO;
        else if (!tail[2]) c = LEN_THREE;
        else               c = LEN_FOUR;
        return c;
    endfunction

    // pixels covered by a group of the given code, anchored at bit 0
    function automatic logic [RUN_MAX-1:0] run_seg(input run_len_e c);
        logic [RUN_MAX-1:0] s;
        case (c)
            LEN_ONE:   s = 4'b0001;
            LEN_TWO:   s = 4'b0011;
            LEN_THREE: s = 4'b0111;
            default:   s = 4'b1111;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/zs_row_store.sv
module zs_row_store #(
    parameter int COLS  = 32,
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [COLS-1:0]  load_bits,
    input  logic [ROW_W-1:0] load_row,
    input  logic             consume,
    input  logic [COLS-1:0]  consume_mask,
    output logic [COLS-1:0]  pend,
    output logic [ROW_W-1:0] row_tag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            row_tag <= '0;
        end else if (load) begin
            pend    <= load_bits;
            row_tag <= load_row;
        end else if (consume) begin
            pend    <= pend & ~consume_mask;
        end
    end

endmodule

// File: rtl/zs_lead_find.sv
module zs_lead_find #(
    parameter int COLS = 32
) (
    input  logic [COLS-1:0]         pend,
    output logic                    any,
    output logic [$clog2(COLS)-1:0] idx
);

    localparam int COL_W = $clog2(COLS);

    function automatic logic [COLS-1:0] sel_mask(input int k);
        logic [COLS-1:0] m;
        for (int c = 0; c < COLS; c++) begin
            m[c] = c[k];
        end
        return m;
    endfunction

    logic [COLS-1:0] lowbit;

    assign any    = |pend;
    assign lowbit = pend & (~pend + COLS'(1));

    for (genvar k = 0; k < COL_W; k++) begin : g_enc
        localparam logic [COLS-1:0] SEL = sel_mask(k);
        assign idx[k] = |(lowbit & SEL);
    end

endmodule

// File: rtl/zs_run_cut.sv
module zs_run_cut #(
    parameter int COLS = 32
) (
    input  logic [COLS-1:0]         pend,
    input  logic [$clog2(COLS)-1:0] idx,
    output zs_pkg::run_len_e        code,
    output logic [COLS-1:0]         mask,
    output logic                    rest_empty
);

    import zs_pkg::*;

    localparam int COL_W = $clog2(COLS);

    logic [RUN_MAX-2:0] tail;
    logic [COLS-1:0]    seg_w;

    always_comb begin
        for (int j = 0; j < RUN_MAX - 1; j++) begin
            int p;
            p = int'(idx) + j + 1;
            if (p < COLS) tail[j] = pend[p[COL_W-1:0]];
            else          tail[j] = 1'b0;
        end
    end

    always_comb begin
        code               = run_code(tail);
        seg_w              = '0;
        seg_w[RUN_MAX-1:0] = run_seg(code);
        mask               = seg_w << idx;
        rest_empty         = ((pend & ~mask) == '0);
    end

endmodule

// File: rtl/zs_row_encoder.sv
module zs_row_encoder #(
    parameter int COLS  = 32,
    parameter int ROW_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    row_valid,
    output logic                    row_ready,
    input  logic [COLS-1:0]         row_hits,
    input  logic [ROW_W-1:0]        row_index,
    output logic                    rec_valid,
    input  logic                    rec_ready,
    output logic [$clog2(COLS)-1:0] rec_col,
    output logic [1:0]              rec_len,
    output logic [ROW_W-1:0]        rec_row,
    output logic                    rec_last
);

    import zs_pkg::*;

    localparam int COL_W = $clog2(COLS);

    typedef struct packed {
        logic [COL_W-1:0] col;
        run_len_e         len;
        logic             last;
    } rec_t;

    logic [COLS-1:0]  pend;
    logic [ROW_W-1:0] row_tag;
    logic             any;
    logic [COL_W-1:0] lead_idx;
    run_len_e         code;
    logic [COLS-1:0]  cut_mask;
    logic             rest_empty;
    logic             take_row;
    logic             take_rec;
    rec_t             rec;

    assign take_row = row_valid & row_ready;
    assign take_rec = rec_valid & rec_ready;

    zs_row_store #(.COLS(COLS), .ROW_W(ROW_W)) u_store (
        .clk          (clk),
        .rst          (rst),
        .load         (take_row),
        .load_bits    (row_hits),
        .load_row     (row_index),
        .consume      (take_rec),
        .consume_mask (cut_mask),
        .pend         (pend),
        .row_tag      (row_tag)
    );

    zs_lead_find #(.COLS(COLS)) u_lead (
        .pend (pend),
        .any  (any),
        .idx  (lead_idx)
    );

    zs_run_cut #(.COLS(COLS)) u_cut (
        .pend       (pend),
        .idx        (lead_idx),
        .code       (code),
        .mask       (cut_mask),
        .rest_empty (rest_empty)
    );

    assign rec.col  = lead_idx;
    assign rec.len  = code;
    assign rec.last = rest_empty;

    assign row_ready = ~any;
    assign rec_valid = any;
    assign rec_col   = rec.col;
    assign rec_len   = rec.len;
    assign rec_last  = rec.last;
    assign rec_row   = row_tag;

endmodule

// File: rtl/zs_row_encoder_chk.sv
module zs_row_encoder_chk #(
    parameter int COLS  = 32,
    parameter int ROW_W = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    row_valid,
    input logic                    row_ready,
    input logic [COLS-1:0]         row_hits,
    input logic [ROW_W-1:0]        row_index,
    input logic                    rec_valid,
    input logic                    rec_ready,
    input logic [$clog2(COLS)-1:0] rec_col,
    input logic [1:0]              rec_len,
    input logic [ROW_W-1:0]        rec_row,
    input logic                    rec_last
);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_col) && $stable(rec_len)
                                       && $stable(rec_row) && $stable(rec_last)));

    p_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_ready && !rec_last) |=> (rec_valid && !row_ready));

    p_free_r7: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_ready && rec_last) |=> row_ready);

    p_ascend_r4: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_ready && !rec_last) |=>
            (int'(rec_col) > int'($past(rec_col)) + int'($past(rec_len))));

    p_fit_r9: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (int'(rec_col) + int'(rec_len) < COLS));

    p_empty_row_r5: assert property (@(posedge clk) disable iff (rst)
        (row_valid && row_ready && (row_hits == '0)) |=> (row_ready && !rec_valid));

    p_row_tag_r6: assert property (@(posedge clk) disable iff (rst)
        (row_valid && row_ready && (row_hits != '0)) |=>
            (rec_valid && rec_row == $past(row_index)));

endmodule

bind zs_row_encoder zs_row_encoder_chk #(.COLS(COLS), .ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .row_valid (row_valid),
    .row_ready (row_ready),
    .row_hits  (row_hits),
    .row_index (row_index),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_col   (rec_col),
    .rec_len   (rec_len),
    .rec_row   (rec_row),
    .rec_last  (rec_last)
);

// File: tb/sim_zs_row_encoder.sv
`timescale 1ns/1ps
module sim_zs_row_encoder;

    localparam int COLS  = 32;
    localparam int ROW_W = 10;
    localparam int COL_W = $clog2(COLS);

    typedef struct {
        int col;
        int len;
        int row;
        bit last;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             row_valid = 1'b0;
    logic             row_ready;
    logic [COLS-1:0]  row_hits = '0;
    logic [ROW_W-1:0] row_index = '0;
    logic             rec_valid;
    logic             rec_ready = 1'b0;
    logic [COL_W-1:0] rec_col;
    logic [1:0]       rec_len;
    logic [ROW_W-1:0] rec_row;
    logic             rec_last;

    int    checks = 0;
    int    errs   = 0;
    bit    done   = 0;
    bit    accepted;
    int    rdy_mode = 0;
    string scen = "reset";

    bit               drv_valid = 0;
    logic [COLS-1:0]  drv_hits  = '0;
    logic [ROW_W-1:0] drv_row   = '0;

    exp_t q[$];

    always #2.5 clk = ~clk;

    zs_row_encoder #(.COLS(COLS), .ROW_W(ROW_W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .row_valid (row_valid),
        .row_ready (row_ready),
        .row_hits  (row_hits),
        .row_index (row_index),
        .rec_valid (rec_valid),
        .rec_ready (rec_ready),
        .rec_col   (rec_col),
        .rec_len   (rec_len),
        .rec_row   (rec_row),
        .rec_last  (rec_last)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s [%s]: actual=%0d expected=%0d", req, what, scen, act, exp);
        end
    endtask

    // behavioural grouping: scan columns, groups of at most four adjacent hits
    function automatic int scan(input logic [COLS-1:0] b, input int row, input bit push);
        int c = 0;
        int n = 0;
        exp_t e;
        while (c < COLS) begin
            if (b[c]) begin
                int len = 1;
                while (len < 4 && c + len < COLS && b[c+len]) len++;
                e.col = c; e.len = len - 1; e.row = row; e.last = 0;
                if (push) q.push_back(e);
                n++;
                c += len;
            end else begin
                c++;
            end
        end
        if (push && n > 0) q[q.size()-1].last = 1;
        return n;
    endfunction

    task automatic compare();
        check("R7", "row_ready", int'(row_ready), int'(q.size() == 0));
        check("R5", "rec_valid", int'(rec_valid), int'(q.size() != 0));
        if (q.size() != 0 && rec_valid) begin
            check("R2", "rec_col",  int'(rec_col),  q[0].col);
            check("R2", "rec_len",  int'(rec_len),  q[0].len);
            check("R6", "rec_row",  int'(rec_row),  q[0].row);
            check("R6", "rec_last", int'(rec_last), int'(q[0].last));
        end
    endtask

    task automatic tick();
        int sz;
        int n;
        @(negedge clk);
        compare();
        case (rdy_mode)
            0:       rec_ready = 1'b1;
            1:       rec_ready = 1'($urandom_range(0, 1));
            default: rec_ready = 1'b0;
        endcase
        row_valid = drv_valid;
        row_hits  = drv_hits;
        row_index = drv_row;
        accepted  = 0;
        sz = q.size();
        if (sz != 0 && rec_ready) void'(q.pop_front());
        if (sz == 0 && row_valid) begin
            n = scan(row_hits, int'(row_index), 1'b1);
            accepted = 1;
        end
    endtask

    task automatic send_row(input logic [COLS-1:0] b, input logic [ROW_W-1:0] r);
        drv_valid = 1; drv_hits = b; drv_row = r;
        do tick(); while (!accepted);
        drv_valid = 0;
    endtask

    task automatic drain();
        while (q.size() != 0) tick();
        tick();
    endtask

    initial begin
        void'($urandom(11));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "row_ready after reset", int'(row_ready), 1);
        check("R1", "rec_valid after reset", int'(rec_valid), 0);

        rdy_mode = 0;
        scen = "R2 single pixel";
        send_row(32'h0000_0020, 10'd1); drain();
        scen = "R2 runs of three and four";
        send_row(32'h00F0_1C00, 10'd2); drain();
        scen = "R3 run of nine split";
        send_row(32'h0000_07FC, 10'd3); drain();
        scen = "R4 scattered ascending";
        send_row(32'h9249_2493, 10'd4); drain();
        scen = "R5 empty row";
        send_row(32'h0000_0000, 10'd5); tick();
        check("R5", "row_ready after empty row", int'(row_ready), 1);
        check("R5", "rec_valid after empty row", int'(rec_valid), 0);
        scen = "R9 edges";
        send_row(32'hC000_0001, 10'd6); drain();
        send_row(32'hF800_0000, 10'd7); drain();

        scen = "R10 full row";
        begin
            int cnt = 0;
            send_row('1, 10'd8);
            while (q.size() != 0) begin tick(); cnt++; end
            check("R10", "cycles to drain full row", cnt, 8);
        end
        tick();

        scen = "R8 stall";
        rdy_mode = 2;
        send_row(32'h00FF_F00F, 10'd9);
        repeat (5) tick();
        rdy_mode = 1;
        drain();

        scen = "R7 back-to-back rows";
        rdy_mode = 0;
        for (int i = 0; i < 20; i++) send_row($urandom, ROW_W'(100 + i));
        drain();

        scen = "R8 R6 random rows";
        rdy_mode = 1;
        for (int i = 0; i < 400; i++) begin
            logic [COLS-1:0] b;
            case (i % 4)
                0:       b = $urandom & $urandom & $urandom;
                1:       b = $urandom | $urandom;
                2:       b = $urandom;
                default: b = (i % 8 == 3) ? '0 : ~($urandom & $urandom & $urandom);
            endcase
            send_row(b, ROW_W'($urandom));
        end
        drain();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL R7 watchdog [%s]: actual=running expected=finished", scen);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule